// File: doc/BRIEF.md
# Trigger Input Pulse Qualifier

This block sits between the two physical trigger inputs and the delay core. A registered source select picks either the front-panel input or the connector input. A chain of synchroniser flops brings the chosen signal into the system clock domain. A small qualifier then counts how many consecutive samples the signal stays high. A rising edge is accepted only once the signal has held high for `MIN_HIGH` samples. The block then emits a trigger strobe that lasts one clock cycle. Glitches and runt pulses are dropped, and a sticky flag records that one was seen.

When the select changes, triggers are blocked for a few cycles. After the switch, the new source must also be seen low before it can arm. A signal that is already high on the new source therefore never looks like an edge. The block also registers the enable for the optional input termination and drives a status indicator from the same register. Both come out of reset in the off state.

Top module: `trig_qualifier`

## Requirements
- R1: While `rst_ni` is low, and right after it is released, `trig_o`, `term_o`, `term_led_o` and `short_flag_o` are all 0.
- R2: `src_sel_i` = 0 selects `front_i` and 1 selects `conn_i`. Pulses on the input that is not selected produce no strobe.
- R3: Take a clean rising edge on the selected input, set up before clock edge E1, with the input then held high. `trig_o` is 0 after edges E1 to E4, 1 after edge E5, and 0 again after edge E6. This is two synchroniser stages followed by the third consecutive high sample.
- R4: A pulse that lasts only one or two clock samples produces no strobe.
- R5: `trig_o` is high for exactly one cycle for each accepted edge, however long the input then stays high.
- R6: After a strobe, the input must be sampled low at least once before another edge can be accepted. Two long pulses separated by a low gap give two strobes.
- R7: A change of `src_sel_i` blocks strobes for 4 cycles. After the change, the input must also be sampled low before it can arm. If the new source is already high, or goes high during the block window, no strobe follows until that source goes low and then high again.
- R8: `short_flag_o` is set when an armed pulse ends before it is accepted. It stays set until `flag_clr_i` is high at a clock edge. If a set and a clear happen at the same edge, the set wins.
- R9: `term_o` takes the value of `term_en_i` one clock edge later. `term_led_o` always equals `term_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| front_i | input | 1 | Front-panel trigger input (asynchronous) |
| conn_i | input | 1 | Connector trigger input (asynchronous) |
| src_sel_i | input | 1 | Source select: 0 front, 1 connector |
| term_en_i | input | 1 | Request to enable the input termination |
| flag_clr_i | input | 1 | Clears the short-pulse flag |
| trig_o | output | 1 | One-cycle trigger strobe |
| term_o | output | 1 | Termination control, 0 at reset |
| term_led_o | output | 1 | Termination status indicator |
| short_flag_o | output | 1 | Sticky flag for a rejected short pulse |

## Verification
The hardest case to reach is a false edge made by the source switch itself. The newly selected input goes high while old data from the other source is still in the synchroniser. To get there, the bench changes the select and raises the connector input at the same negative edge. The rising level then travels through the synchroniser entirely inside the block window. The bench checks that no strobe follows. It then drops the level and raises it again, and checks that exactly one strobe appears.

// File: rtl/trig_qual_pkg.sv
package trig_qual_pkg;
  typedef enum logic {
    SRC_FRONT = 1'b0,
    SRC_CONN  = 1'b1
  } trig_src_e;
endpackage

// File: rtl/tq_sync.sv
module tq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[i] <= 1'b0;
        else         stage_q[i] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[i] <= 1'b0;
        else         stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/tq_src_ctl.sv
module tq_src_ctl
  import trig_qual_pkg::*;
#(
  parameter int MASK_CYCLES = 4,
  localparam int MW = $clog2(MASK_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic front_i,
  input  logic conn_i,
  input  logic src_sel_i,
  output logic raw_o,
  output logic mask_o
);
  trig_src_e       sel_q;
  logic [MW-1:0]   mask_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q      <= SRC_FRONT;
      mask_cnt_q <= '0;
    end else begin
      sel_q <= trig_src_e'(src_sel_i);
      if (src_sel_i != sel_q)   mask_cnt_q <= MW'(MASK_CYCLES);
      else if (mask_cnt_q != 0) mask_cnt_q <= mask_cnt_q - 1'b1;
    end
  end

  assign raw_o  = (sel_q == SRC_CONN) ? conn_i : front_i;
  assign mask_o = (mask_cnt_q != '0);

  // R7: a select change opens the mask window on the next cycle
  p_mask_open_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i != sel_q) |=> mask_o);
endmodule

// File: rtl/tq_width_qual.sv
module tq_width_qual #(
  parameter int MIN_HIGH = 3,
  localparam int CW = $clog2(MIN_HIGH + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic mask_i,
  input  logic flag_clr_i,
  output logic trig_o,
  output logic short_flag_o
);
  logic [CW-1:0] cnt_q;
  logic          armed_q, trig_q, flag_q;
  logic          fire, short_det;

  assign fire      = sync_i && armed_q && !mask_i && (cnt_q == CW'(MIN_HIGH - 1));
  // armed pulse fell before acceptance
  assign short_det = !sync_i && armed_q && !mask_i && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      trig_q  <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      trig_q <= fire;
      if (mask_i) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
      end else if (sync_i) begin
        if (cnt_q != CW'(MIN_HIGH)) cnt_q <= cnt_q + 1'b1;
        if (fire) armed_q <= 1'b0;
      end else begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end
      if (short_det)       flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign trig_o       = trig_q;
  assign short_flag_o = flag_q;

  p_single_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);
  p_strobe_after_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> $past(sync_i));
  p_no_strobe_masked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_i |=> !trig_o);
  p_flag_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (short_flag_o && !flag_clr_i) |=> short_flag_o);
endmodule

// File: rtl/trig_qualifier.sv
module trig_qualifier #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HIGH    = 3,
  parameter int MASK_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic front_i,
  input  logic conn_i,
  input  logic src_sel_i,
  input  logic term_en_i,
  input  logic flag_clr_i,
  output logic trig_o,
  output logic term_o,
  output logic term_led_o,
  output logic short_flag_o
);
  logic raw, mask, sync, term_q;

  tq_src_ctl #(.MASK_CYCLES(MASK_CYCLES)) u_src (
    .clk_i, .rst_ni, .front_i, .conn_i, .src_sel_i,
    .raw_o(raw), .mask_o(mask)
  );

  tq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(sync)
  );

  tq_width_qual #(.MIN_HIGH(MIN_HIGH)) u_qual (
    .clk_i, .rst_ni, .sync_i(sync), .mask_i(mask), .flag_clr_i,
    .trig_o, .short_flag_o
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) term_q <= 1'b0;
    else         term_q <= term_en_i;

  assign term_o     = term_q;
  assign term_led_o = term_q;

  // R1: termination held off during reset
  always_comb
    if (!rst_ni) a_term_off_reset_r1: assert (!term_o);
endmodule

// File: tb/trig_qualifier_test.sv
`timescale 1ns/1ps
module trig_qualifier_test;
  logic clk_i = 0, rst_ni = 0;
  logic front_i = 0, conn_i = 0, src_sel_i = 0, term_en_i = 0, flag_clr_i = 0;
  logic trig_o, term_o, term_led_o, short_flag_o;
  int checks = 0, fails = 0, trig_cnt = 0;

  trig_qualifier uut (.*);

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) if (trig_o) trig_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse(input bit on_conn, input int len);
    @(negedge clk_i);
    if (on_conn) conn_i = 1; else front_i = 1;
    idle(len);
    if (on_conn) conn_i = 0; else front_i = 0;
  endtask

  task automatic t_reset;
    idle(3);
    chk(trig_o == 0, "R1 trig", trig_o, 0);
    chk(term_o == 0, "R1 term", term_o, 0);
    chk(term_led_o == 0, "R1 led", term_led_o, 0);
    chk(short_flag_o == 0, "R1 flag", short_flag_o, 0);
    rst_ni = 1;
    idle(4);
    chk(trig_o == 0 && short_flag_o == 0, "R1 after release", trig_o, 0);
  endtask

  task automatic t_latency;  // R3, R5
    @(negedge clk_i);
    front_i = 1;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk_i);
      chk(trig_o == (i == 5), "R3 latency", trig_o, (i == 5));
    end
    idle(20);
    front_i = 0;
    idle(6);
  endtask

  task automatic t_short;  // R4, R8
    trig_cnt = 0;
    pulse(0, 1); idle(8);
    chk(trig_cnt == 0, "R4 one-sample pulse", trig_cnt, 0);
    chk(short_flag_o == 1, "R8 flag set", short_flag_o, 1);
    flag_clr_i = 1; idle(1); flag_clr_i = 0; idle(1);
    chk(short_flag_o == 0, "R8 flag cleared", short_flag_o, 0);
    pulse(0, 2); idle(8);
    chk(trig_cnt == 0, "R4 two-sample pulse", trig_cnt, 0);
    chk(short_flag_o == 1, "R8 flag set 2", short_flag_o, 1);
    idle(10);
    chk(short_flag_o == 1, "R8 flag held", short_flag_o, 1);
    flag_clr_i = 1; idle(1); flag_clr_i = 0; idle(1);
    pulse(0, 3); idle(8);
    chk(trig_cnt == 1, "R4 three-sample accepted", trig_cnt, 1);
    chk(short_flag_o == 0, "R8 no flag on accepted", short_flag_o, 0);
  endtask

  task automatic t_set_wins;  // R8
    @(negedge clk_i); front_i = 1;
    idle(1); front_i = 0;
    idle(2); flag_clr_i = 1;         // clear held across the set edge
    idle(3); flag_clr_i = 0;
    idle(1);
    chk(short_flag_o == 0, "R8 clear after set", short_flag_o, 0);
    @(negedge clk_i); front_i = 1;
    idle(1); front_i = 0;
    idle(2);
    flag_clr_i = 1; idle(1); flag_clr_i = 0;  // one-cycle clear before fall seen
    idle(1);
    chk(short_flag_o == 1, "R8 set wins or later set", short_flag_o, 1);
    flag_clr_i = 1; idle(1); flag_clr_i = 0; idle(2);
  endtask

  task automatic t_rearm;  // R5, R6
    trig_cnt = 0;
    pulse(0, 40); idle(8);
    chk(trig_cnt == 1, "R5 long pulse one strobe", trig_cnt, 1);
    pulse(0, 10); idle(2);
    pulse(0, 10); idle(8);
    chk(trig_cnt == 3, "R6 rearm after low", trig_cnt, 3);
  endtask

  task automatic t_source;  // R2
    trig_cnt = 0;
    pulse(1, 8); idle(8);
    chk(trig_cnt == 0, "R2 conn ignored on front", trig_cnt, 0);
    @(negedge clk_i); src_sel_i = 1; idle(10);
    pulse(0, 8); idle(8);
    chk(trig_cnt == 0, "R2 front ignored on conn", trig_cnt, 0);
    pulse(1, 8); idle(8);
    chk(trig_cnt == 1, "R2 conn selected", trig_cnt, 1);
    @(negedge clk_i); src_sel_i = 0; idle(10);
    pulse(0, 8); idle(8);
    chk(trig_cnt == 2, "R2 front selected", trig_cnt, 2);
  endtask

  task automatic t_mask;  // R7
    trig_cnt = 0;
    @(negedge clk_i); src_sel_i = 1; conn_i = 1;
    idle(20);
    chk(trig_cnt == 0, "R7 rise in mask window", trig_cnt, 0);
    conn_i = 0; idle(3);
    pulse(1, 8); idle(8);
    chk(trig_cnt == 1, "R7 trigger after low", trig_cnt, 1);
    @(negedge clk_i); front_i = 1; idle(6);
    @(negedge clk_i); src_sel_i = 0; idle(20);
    chk(trig_cnt == 1, "R7 already-high source", trig_cnt, 1);
    front_i = 0; idle(3);
    pulse(0, 8); idle(8);
    chk(trig_cnt == 2, "R7 front after low", trig_cnt, 2);
  endtask

  task automatic t_term;  // R9
    @(negedge clk_i); term_en_i = 1;
    @(negedge clk_i);
    chk(term_o == 1, "R9 term on", term_o, 1);
    chk(term_led_o == term_o, "R9 led on", term_led_o, term_o);
    term_en_i = 0;
    @(negedge clk_i);
    chk(term_o == 0 && term_led_o == 0, "R9 term off", term_o, 0);
  endtask

  initial begin
    t_reset;
    t_latency;
    t_short;
    t_set_wins;
    t_rearm;
    t_source;
    t_mask;
    t_term;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule